// File: doc/BRIEF.md
# Hypercube Neighbour Slot Exchange

This block holds a set of processing nodes wired as a binary hypercube of `DIM` dimensions, with `2**DIM` nodes labelled by `DIM`-bit numbers. Each node owns an outgoing buffer and an incoming buffer of 32 word slots each. Software-side logic fills the outgoing buffers through a single write port. It then pulses `start`, and every node trades words with all of its neighbours at once. After `done`, the incoming buffers can be read back through a single read port.

The slot number chooses the wire. A word placed in outgoing slot `k` with `1 <= k <= DIM` travels across dimension `k`, so it reaches the node whose label has bit `k-1` (counting from the least significant bit) inverted. Slots `17 .. 16+DIM` give a second lane over the same wires. Every word arrives in the same slot number it left from. Each edge therefore swaps four words per operation, and each node sends and receives `2*DIM` words. The exchange always drives every wire. A node that needs only some directions reads only the slots it cares about.

Each incoming slot has a valid flag. A swap sets the flag on every slot it writes, and a `clr` pulse drops all flags without disturbing the stored words.

Top module: `hcube_swap`

## Requirements
- R1: While `rst` is high at a clock edge, all outgoing and incoming words become zero, all valid flags clear, and `done` is low on the following cycle.
- R2: A `start` accepted at clock edge E moves the data at edge E+1. `done` is high for exactly the one cycle between E+1 and E+2, so it is seen two cycles after `start` was driven.
- R3: For slot `k` in `1..DIM`, after a swap, incoming slot `k` of node `n` holds the word that was in outgoing slot `k` of node `n XOR 2**(k-1)` at the data-moving edge.
- R4: For slot `k` in `17..16+DIM`, after a swap, incoming slot `k` of node `n` holds outgoing slot `k` of node `n XOR 2**(k-17)`.
- R5: Slot 0, slot 16, slots `DIM+1..15` and slots above `16+DIM` are never written by a swap: their incoming word stays as it was and their valid flag stays 0.
- R6: A swap sets the valid flag of every slot it writes. A `clr` pulse alone clears all valid flags and leaves the incoming words unchanged. If a clear and a data move fall on the same edge, the flags written by the move end up set.
- R7: A `start` seen while a swap is moving its data is ignored. It causes neither an extra `done` nor a second data move.
- R8: A `start` seen in the `done` cycle begins a new swap at once. That swap moves the outgoing data as it stands one edge later and raises `done` again two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable for the outgoing buffers |
| wr_node | input | DIM | Node label for the write |
| wr_slot | input | 5 | Slot index for the write |
| wr_data | input | W | Word to store |
| start | input | 1 | Single-cycle request to run a swap |
| clr | input | 1 | Clears every incoming valid flag |
| rd_node | input | DIM | Node label for the read |
| rd_slot | input | 5 | Slot index for the read |
| rd_data | output | W | Incoming word at the addressed node and slot |
| rd_valid | output | 1 | Valid flag at the addressed node and slot |
| done | output | 1 | One-cycle completion pulse |

## Verification
The outgoing buffers are filled with words that encode node, slot and round. A misrouted word, such as one sent on the wrong dimension, into the wrong lane or to the wrong slot, therefore shows up as a value that differs from the expected one. A full read sweep after each swap covers both lanes on every dimension and also the untouched slots, and the sweep after reset checks the cleared state. A `start` held for three cycles separates an ignored request during data movement from a restart in the `done` cycle. The words are rewritten between the two swaps, so the second exchange proves that it sampled fresh data. Further patterns check valid-flag behaviour: a clear that lands on the same edge as a data move, followed by a clear alone, which must keep the words.

// File: rtl/hcube_pkg.sv
package hcube_pkg;

    localparam int SLOTS   = 32;
    localparam int SLOT_W  = 5;
    localparam int LANE2   = 16;
    localparam int MAX_DIM = 11;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MOVE = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        logic commit;
        logic done;
    } swap_ctl_t;

    // Dimension (wire) carried by a slot, 0 when the slot carries nothing.
    function automatic int slot_wire(input int s, input int dim);
        if (s >= 1 && s <= dim) return s;
        if (s >= LANE2 + 1 && s <= LANE2 + dim) return s - LANE2;
        return 0;
    endfunction

    function automatic logic [SLOTS-1:0] traffic_mask(input int dim);
        logic [SLOTS-1:0] m;
        m = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (slot_wire(s, dim) != 0) m[s] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hcube_ctrl.sv
module hcube_ctrl
    import hcube_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output swap_ctl_t ctl
);

    phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
        end else begin
            unique case (ph_q)
                PH_IDLE: ph_q <= start ? PH_MOVE : PH_IDLE;
                PH_MOVE: ph_q <= PH_DONE;
                PH_DONE: ph_q <= start ? PH_MOVE : PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.commit = (ph_q == PH_MOVE);
        ctl.done   = (ph_q == PH_DONE);
    end

    // R2: the data move is always followed by the completion pulse
    a_r2_done_after_move: assert property (@(posedge clk) disable iff (rst)
        ctl.commit |=> ctl.done);

    // R2: completion lasts a single cycle
    a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> !ctl.done);

    // R7: a request during data movement does not start another move
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (ctl.commit && start) |=> !ctl.commit);

    // R8: a request during completion restarts immediately
    a_r8_restart_in_done: assert property (@(posedge clk) disable iff (rst)
        (ctl.done && start) |=> ctl.commit);

endmodule

// File: rtl/hcube_sendbuf.sv
module hcube_sendbuf
    import hcube_pkg::*;
#(
    parameter int DIM = 4,
    parameter int W   = 16,
    localparam int NODES = 1 << DIM
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [DIM-1:0] wr_node,
    input  slot_t          wr_slot,
    input  logic [W-1:0]   wr_data,
    output logic [W-1:0]   out_q [NODES][SLOTS]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NODES; n++) begin
                for (int s = 0; s < SLOTS; s++) begin
                    out_q[n][s] <= '0;
                end
            end
        end else if (wr_en) begin
            out_q[wr_node][wr_slot] <= wr_data;
        end
    end

endmodule

// File: rtl/hcube_xbar.sv
module hcube_xbar
    import hcube_pkg::*;
#(
    parameter int DIM = 4,
    parameter int W   = 16,
    localparam int NODES = 1 << DIM
) (
    input  logic [W-1:0] tx [NODES][SLOTS],
    output logic [W-1:0] rx [NODES][SLOTS]
);

    for (genvar n = 0; n < NODES; n++) begin : g_node
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            localparam int WIRE = slot_wire(s, DIM);
            if (WIRE != 0) begin : g_wire
                localparam int PEER = n ^ (1 << (WIRE - 1));
                assign rx[n][s] = tx[PEER][s];
            end else begin : g_quiet
                assign rx[n][s] = tx[n][s];
            end
        end
    end

endmodule

// File: rtl/hcube_recvbuf.sv
module hcube_recvbuf
    import hcube_pkg::*;
#(
    parameter int DIM = 4,
    parameter int W   = 16,
    localparam int NODES = 1 << DIM
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           commit,
    input  logic           clr,
    input  logic [W-1:0]   rx [NODES][SLOTS],
    input  logic [DIM-1:0] rd_node,
    input  slot_t          rd_slot,
    output logic [W-1:0]   rd_data,
    output logic           rd_valid
);

    localparam logic [SLOTS-1:0] LIVE = traffic_mask(DIM);

    logic [W-1:0]     mem_q [NODES][SLOTS];
    logic [SLOTS-1:0] vld_q [NODES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NODES; n++) begin
                vld_q[n] <= '0;
                for (int s = 0; s < SLOTS; s++) begin
                    mem_q[n][s] <= '0;
                end
            end
        end else begin
            for (int n = 0; n < NODES; n++) begin
                if (clr) vld_q[n] <= '0;
                if (commit) begin
                    for (int s = 0; s < SLOTS; s++) begin
                        if (LIVE[s]) begin
                            mem_q[n][s] <= rx[n][s];
                            vld_q[n][s] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign rd_data  = mem_q[rd_node][rd_slot];
    assign rd_valid = vld_q[rd_node][rd_slot];

    for (genvar n = 0; n < NODES; n++) begin : g_chk
        // R5: a swap leaves the idle slots 0 and 16 untouched
        a_r5_idle_slots_kept: assert property (@(posedge clk) disable iff (rst)
            commit |=> ($stable(mem_q[n][0]) && $stable(mem_q[n][LANE2])));

        // R6: a move marks every slot it carries as valid
        a_r6_move_sets_flags: assert property (@(posedge clk) disable iff (rst)
            commit |=> ((vld_q[n] & LIVE) == LIVE));

        // R6: a clear on its own leaves no flag standing
        a_r6_clear_drops_flags: assert property (@(posedge clk) disable iff (rst)
            (clr && !commit) |=> (vld_q[n] == '0));

        // R5: idle slots never gain a flag
        a_r5_idle_never_valid: assert property (@(posedge clk) disable iff (rst)
            commit |=> ((vld_q[n] & ~LIVE) == '0));
    end

endmodule

// File: rtl/hcube_swap.sv
module hcube_swap
    import hcube_pkg::*;
#(
    parameter int DIM = 4,
    parameter int W   = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [DIM-1:0] wr_node,
    input  logic [4:0]     wr_slot,
    input  logic [W-1:0]   wr_data,
    input  logic           start,
    input  logic           clr,
    input  logic [DIM-1:0] rd_node,
    input  logic [4:0]     rd_slot,
    output logic [W-1:0]   rd_data,
    output logic           rd_valid,
    output logic           done
);

    localparam int NODES = 1 << DIM;

    initial begin
        if (DIM < 1 || DIM > MAX_DIM) $error("hcube_swap: DIM out of range");
    end

    swap_ctl_t    ctl;
    logic [W-1:0] tx_w [NODES][SLOTS];
    logic [W-1:0] rx_w [NODES][SLOTS];

    hcube_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl)
    );

    hcube_sendbuf #(.DIM(DIM), .W(W)) u_send (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_node (wr_node),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .out_q   (tx_w)
    );

    hcube_xbar #(.DIM(DIM), .W(W)) u_xbar (
        .tx (tx_w),
        .rx (rx_w)
    );

    hcube_recvbuf #(.DIM(DIM), .W(W)) u_recv (
        .clk      (clk),
        .rst      (rst),
        .commit   (ctl.commit),
        .clr      (clr),
        .rx       (rx_w),
        .rd_node  (rd_node),
        .rd_slot  (rd_slot),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign done = ctl.done;

    // R1: reset leaves the completion pulse low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !done);

endmodule

// File: tb/test_hcube_swap.sv
module test_hcube_swap;

    localparam int DIM   = 4;
    localparam int W     = 16;
    localparam int NODES = 1 << DIM;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [DIM-1:0] wr_node = '0;
    logic [4:0]     wr_slot = '0;
    logic [W-1:0]   wr_data = '0;
    logic           start = 1'b0;
    logic           clr = 1'b0;
    logic [DIM-1:0] rd_node = '0;
    logic [4:0]     rd_slot = '0;
    logic [W-1:0]   rd_data;
    logic           rd_valid;
    logic           done;

    hcube_swap #(.DIM(DIM), .W(W)) i_hcube_swap (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_node(wr_node),
        .wr_slot(wr_slot), .wr_data(wr_data), .start(start), .clr(clr),
        .rd_node(rd_node), .rd_slot(rd_slot), .rd_data(rd_data),
        .rd_valid(rd_valid), .done(done)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    string cur_tag = "R1";

    int m_send [NODES][32];
    int m_recv [NODES][32];
    int m_vld  [NODES][32];
    int m_phase = 0;

    function automatic int wire_of(input int s);
        if (s >= 1 && s <= DIM) return s;
        if (s >= 17 && s <= 16 + DIM) return s - 16;
        return 0;
    endfunction

    function automatic string slot_tag(input int s);
        if (s >= 1 && s <= DIM) return "R3";
        if (s >= 17 && s <= 16 + DIM) return "R4";
        return "R5";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated on each edge, compared 1 ns later.
    always @(posedge clk) begin
        int    commit;
        int    wi;
        int    exp_d;
        string tg;
        commit = (m_phase == 1);
        if (rst) begin
            m_phase = 0;
            for (int n = 0; n < NODES; n++)
                for (int s = 0; s < 32; s++) begin
                    m_send[n][s] = 0; m_recv[n][s] = 0; m_vld[n][s] = 0;
                end
        end else begin
            if (clr)
                for (int n = 0; n < NODES; n++)
                    for (int s = 0; s < 32; s++) m_vld[n][s] = 0;
            if (commit == 1)
                for (int n = 0; n < NODES; n++)
                    for (int s = 0; s < 32; s++) begin
                        wi = wire_of(s);
                        if (wi != 0) begin
                            m_recv[n][s] = m_send[n ^ (1 << (wi - 1))][s];
                            m_vld[n][s]  = 1;
                        end
                    end
            if (m_phase == 1)      m_phase = 2;
            else if (start)        m_phase = 1;
            else                   m_phase = 0;
            if (wr_en) m_send[wr_node][wr_slot] = int'(wr_data);
        end
        #1;
        tg = (cur_tag != "") ? cur_tag : "R2";
        chk(done === (m_phase == 2), tg, "done", int'(done), int'(m_phase == 2));
        tg = (cur_tag != "") ? cur_tag : slot_tag(rd_slot);
        exp_d = m_recv[rd_node][rd_slot] & ((1 << W) - 1);
        chk(rd_data === exp_d[W-1:0], tg, "rd_data", int'(rd_data), exp_d);
        tg = (cur_tag != "") ? cur_tag : "R6";
        chk(rd_valid === (m_vld[rd_node][rd_slot] != 0), tg, "rd_valid",
            int'(rd_valid), m_vld[rd_node][rd_slot]);
    end

    task automatic fill(input int k);
        for (int n = 0; n < NODES; n++)
            for (int s = 0; s < 32; s++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_node = DIM'(n); wr_slot = 5'(s);
                wr_data = W'(n * 37 + s * 5 + k * 101 + 1);
            end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sweep();
        for (int n = 0; n < NODES; n++)
            for (int s = 0; s < 32; s++) begin
                @(negedge clk);
                rd_node = DIM'(n); rd_slot = 5'(s);
            end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        sweep();

        // R3 / R4 / R5 / R2: plain swap
        cur_tag = "";
        fill(1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        sweep();

        // R6: clear alone keeps the words, drops the flags
        cur_tag = "R6";
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        sweep();

        // R7 then R8: start held three cycles, data changed in between
        cur_tag = "";
        fill(2);
        cur_tag = "R7";
        @(negedge clk); start = 1'b1;
        @(negedge clk); wr_en = 1'b1; wr_node = '0; wr_slot = 5'd1; wr_data = 16'hBEEF;
        @(negedge clk); wr_en = 1'b0; cur_tag = "R8";
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        cur_tag = "";
        sweep();

        // R6: clear on the same edge as the data move
        cur_tag = "R6";
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        sweep();
        fill(3);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        repeat (2) @(negedge clk);
        sweep();

        finish_run();
    end

endmodule